// File: doc/BRIEF.md
# Microcoded Control Sequencer

This block is the control half of a small bus-based processor core. It keeps a micro-state register and, on every clock, looks up one row of a control table. The row gives the 17 control strobes for the shared datapath bus (which source drives the bus, which register loads from it, which ALU operation to apply) and the micro-state for the next cycle. The table is addressed by the concatenation `{micro-state, opcode, compare flag, memory busy}`. There is no separate sequencing logic: opcode dispatch, memory wait states and the branch decision are all ordinary table rows.

Each instruction starts with a shared fetch routine: the memory address register takes the program counter, the instruction register loads from memory, the PC is incremented by four, and the same step dispatches on the 7-bit opcode to a per-instruction micro-routine. Routines exist for register-register ALU, register-immediate ALU, load, store, jump and branch-if-equal. Each routine returns to the first fetch state when it finishes. Any state that touches memory holds in place while the memory reports busy.

Top module: `useqSequencer`

## Requirements
- R1: A synchronous active-high reset (`rst`) puts the sequencer in the first fetch state. While it sits there, the outputs are drvReg=1, regSel=0 (PC) and ldMa=1, and every other strobe and selector is 0.
- R2: The fetch routine runs four states in order. First, PC onto the bus into MA (drvReg, regSel=0, ldMa). Second, memory into IR (drvMem, ldIr). Third, PC into A (drvReg, regSel=0, ldA). Fourth, ALU result with aluSel=2 (A+4) written to the PC (drvAlu, regSel=0, regWr).
- R3: In the three memory states (instruction read, load data, store data), memBusy=1 holds the state. During the hold, ldIr, ldA, ldB, ldMa and regWr are 0, while the bus-drive and memWr strobes stay as in the state's normal word. In every other state memBusy has no effect.
- R4: The fourth fetch state selects the next routine from the opcode: 0110011 for ALU, 0010011 for ALU-immediate, 0000011 for load, 0100011 for store, 1101111 for jump, and 1100011 for branch.
- R5: The ALU routine loads A from rs1 (regSel=1), then B from rs2 (regSel=2). It then writes the ALU result with aluSel=4 (instruction function) to rd (regSel=3) and returns to fetch.
- R6: The ALU-immediate routine loads A from rs1, then B from the immediate unit with immSel=0 (I-format), writes the aluSel=4 result to rd, and returns to fetch.
- R7: The load routine loads A from rs1 and B from the immSel=0 immediate. It then loads MA with the aluSel=1 (A+B) result, writes memory data to rd (drvMem, regSel=3, regWr), and returns to fetch.
- R8: The store routine loads A from rs1 and B from the immSel=1 (S-format) immediate, then loads MA with A+B. It then drives rs2 onto the bus with memWr=1 and returns to fetch.
- R9: The jump routine loads A from the PC, then loads A with aluSel=3 (A-4), then B from the immSel=3 (J-format) immediate. It then writes A+B to the PC and returns to fetch.
- R10: The branch routine loads A from rs1 and B from rs2, then spends one decision state with all strobes 0. With cmpEq=1 it runs the taken routine: A from PC, A-4 into A, B from immSel=2 (B-format), and A+B written to the PC. With cmpEq=0 it returns to fetch. cmpEq has no effect in any other state.
- R11: An opcode outside the R4 list still takes the PC increment in the fourth fetch state, then returns to the first fetch state.
- R12: At most one of drvReg, drvImm, drvAlu and drvMem is 1 in any cycle. Selector fields that a state does not use read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Active-high reset |
| opcode | input | 7 | Opcode field of the instruction register |
| cmpEq | input | 1 | Datapath flag: A equals B |
| memBusy | input | 1 | Memory has not completed the current access |
| ldIr | output | 1 | Instruction register loads from bus |
| ldA | output | 1 | A operand register loads from bus |
| ldB | output | 1 | B operand register loads from bus |
| ldMa | output | 1 | Memory address register loads from bus |
| regWr | output | 1 | Register file writes bus value |
| memWr | output | 1 | Memory write request |
| drvReg | output | 1 | Register file drives bus |
| drvImm | output | 1 | Immediate unit drives bus |
| drvAlu | output | 1 | ALU drives bus |
| drvMem | output | 1 | Memory drives bus |
| regSel | output | 2 | Register select: 0 PC, 1 rs1, 2 rs2, 3 rd |
| immSel | output | 2 | Immediate format: 0 I, 1 S, 2 B, 3 J |
| aluSel | output | 3 | ALU op: 0 none, 1 A+B, 2 A+4, 3 A-4, 4 function |

## Verification
The assertions watch properties that hold on every cycle. The bus never has two drivers. A busy memory state holds its micro-state and loads nothing. The first fetch state always advances, a not-taken branch and an unknown opcode both land back in fetch, and the micro-state never takes an unused encoding. The exact strobe word of each step, the order of each routine, the dispatch for each opcode, and the fact that cmpEq and memBusy are ignored outside their own states can only be shown by the bench, which walks every routine with stalls and stray flag values injected.

// File: rtl/useqPkg.sv
package useqPkg;

  localparam int OP_W = 7;
  localparam int ST_W = 6;

  localparam logic [OP_W-1:0] OPC_ALU    = 7'b0110011;
  localparam logic [OP_W-1:0] OPC_ALUI   = 7'b0010011;
  localparam logic [OP_W-1:0] OPC_LOAD   = 7'b0000011;
  localparam logic [OP_W-1:0] OPC_STORE  = 7'b0100011;
  localparam logic [OP_W-1:0] OPC_JUMP   = 7'b1101111;
  localparam logic [OP_W-1:0] OPC_BRANCH = 7'b1100011;

  typedef enum logic [ST_W-1:0] {
    ST_FETCH0 = 6'd0, ST_FETCH1, ST_FETCH2, ST_FETCH3,
    ST_ALU0, ST_ALU1, ST_ALU2,
    ST_ALUI0, ST_ALUI1, ST_ALUI2,
    ST_LD0, ST_LD1, ST_LD2, ST_LD3,
    ST_ST0, ST_ST1, ST_ST2, ST_ST3,
    ST_JMP0, ST_JMP1, ST_JMP2, ST_JMP3,
    ST_BR0, ST_BR1, ST_BR2,
    ST_BT0, ST_BT1, ST_BT2, ST_BT3
  } uState_e;

  localparam int ST_LAST = 28;

  typedef enum logic [1:0] {RS_PC = 2'd0, RS_RS1, RS_RS2, RS_RD} regSel_e;
  typedef enum logic [1:0] {IM_I = 2'd0, IM_S, IM_B, IM_J} immSel_e;
  typedef enum logic [2:0] {AL_NONE = 3'd0, AL_ADD, AL_INC4, AL_DEC4, AL_FUNC} aluSel_e;

  typedef struct packed {
    logic    ldIr;
    logic    ldA;
    logic    ldB;
    logic    ldMa;
    logic    regWr;
    logic    memWr;
    logic    drvReg;
    logic    drvImm;
    logic    drvAlu;
    logic    drvMem;
    regSel_e regSel;
    immSel_e immSel;
    aluSel_e aluSel;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
  localparam int ADDR_W = ST_W + OP_W + 2;

  function automatic ctrl_t cRegToA(regSel_e s);
    ctrl_t c = '0;
    c.drvReg = 1'b1; c.regSel = s; c.ldA = 1'b1;
    return c;
  endfunction

  function automatic ctrl_t cRegToB(regSel_e s);
    ctrl_t c = '0;
    c.drvReg = 1'b1; c.regSel = s; c.ldB = 1'b1;
    return c;
  endfunction

  function automatic ctrl_t cRegToMa(regSel_e s);
    ctrl_t c = '0;
    c.drvReg = 1'b1; c.regSel = s; c.ldMa = 1'b1;
    return c;
  endfunction

  function automatic ctrl_t cRegToMem(regSel_e s);
    ctrl_t c = '0;
    c.drvReg = 1'b1; c.regSel = s; c.memWr = 1'b1;
    return c;
  endfunction

  function automatic ctrl_t cImmToB(immSel_e f);
    ctrl_t c = '0;
    c.drvImm = 1'b1; c.immSel = f; c.ldB = 1'b1;
    return c;
  endfunction

  function automatic ctrl_t cAluToA(aluSel_e op);
    ctrl_t c = '0;
    c.drvAlu = 1'b1; c.aluSel = op; c.ldA = 1'b1;
    return c;
  endfunction

  function automatic ctrl_t cAluToMa(aluSel_e op);
    ctrl_t c = '0;
    c.drvAlu = 1'b1; c.aluSel = op; c.ldMa = 1'b1;
    return c;
  endfunction

  function automatic ctrl_t cAluToReg(aluSel_e op, regSel_e dst);
    ctrl_t c = '0;
    c.drvAlu = 1'b1; c.aluSel = op; c.regSel = dst; c.regWr = 1'b1;
    return c;
  endfunction

  function automatic ctrl_t cMemToIr();
    ctrl_t c = '0;
    c.drvMem = 1'b1; c.ldIr = 1'b1;
    return c;
  endfunction

  function automatic ctrl_t cMemToReg(regSel_e dst);
    ctrl_t c = '0;
    c.drvMem = 1'b1; c.regSel = dst; c.regWr = 1'b1;
    return c;
  endfunction

  // Wait-state version of a memory word: keep the request, drop every load.
  function automatic ctrl_t cStall(ctrl_t base);
    ctrl_t c = base;
    c.ldIr = 1'b0; c.ldA = 1'b0; c.ldB = 1'b0; c.ldMa = 1'b0; c.regWr = 1'b0;
    return c;
  endfunction

  function automatic logic isKnownOp(logic [OP_W-1:0] op);
    return (op == OPC_ALU) || (op == OPC_ALUI) || (op == OPC_LOAD) ||
           (op == OPC_STORE) || (op == OPC_JUMP) || (op == OPC_BRANCH);
  endfunction

endpackage

// File: rtl/useqStateReg.sv
module useqStateReg
  import useqPkg::*;
#(
  parameter bit SYNC_RST = 1'b1
) (
  input  logic    clk,
  input  logic    rst,
  input  uState_e nextState,
  output uState_e curState
);

  generate
    if (SYNC_RST) begin : g_syncRst
      always_ff @(posedge clk) begin
        if (rst) curState <= ST_FETCH0;
        else     curState <= nextState;
      end
    end else begin : g_asyncRst
      always_ff @(posedge clk or posedge rst) begin
        if (rst) curState <= ST_FETCH0;
        else     curState <= nextState;
      end
    end
  endgenerate

  // R1: the register never leaves the defined set of micro-states
  a_r1_legal_state: assert property (@(posedge clk) disable iff (rst)
    (int'(curState) <= ST_LAST));

endmodule

// File: rtl/useqTable.sv
module useqTable
  import useqPkg::*;
(
  input  uState_e          curState,
  input  logic [OP_W-1:0]  opcode,
  input  logic             cmpEq,
  input  logic             memBusy,
  output ctrl_t            ctrl,
  output uState_e          nextState
);

  logic [ADDR_W-1:0] romAddr;
  assign romAddr = {curState, opcode, cmpEq, memBusy};

  // Flat table: one row per address pattern, first match wins.
  always_comb begin
    ctrl      = '0;
    nextState = ST_FETCH0;
    priority casez (romAddr)
      // fetch
      {ST_FETCH0, {OP_W{1'b?}}, 1'b?, 1'b?}: begin ctrl = cRegToMa(RS_PC);  nextState = ST_FETCH1; end
      {ST_FETCH1, {OP_W{1'b?}}, 1'b?, 1'b1}: begin ctrl = cStall(cMemToIr()); nextState = ST_FETCH1; end
      {ST_FETCH1, {OP_W{1'b?}}, 1'b?, 1'b0}: begin ctrl = cMemToIr();       nextState = ST_FETCH2; end
      {ST_FETCH2, {OP_W{1'b?}}, 1'b?, 1'b?}: begin ctrl = cRegToA(RS_PC);   nextState = ST_FETCH3; end
      // dispatch
      {ST_FETCH3, OPC_ALU,    1'b?, 1'b?}: begin ctrl = cAluToReg(AL_INC4, RS_PC); nextState = ST_ALU0;  end
      {ST_FETCH3, OPC_ALUI,   1'b?, 1'b?}: begin ctrl = cAluToReg(AL_INC4, RS_PC); nextState = ST_ALUI0; end
      {ST_FETCH3, OPC_LOAD,   1'b?, 1'b?}: begin ctrl = cAluToReg(AL_INC4, RS_PC); nextState = ST_LD0;   end
      {ST_FETCH3, OPC_STORE,  1'b?, 1'b?}: begin ctrl = cAluToReg(AL_INC4, RS_PC); nextState = ST_ST0;   end
      {ST_FETCH3, OPC_JUMP,   1'b?, 1'b?}: begin ctrl = cAluToReg(AL_INC4, RS_PC); nextState = ST_JMP0;  end
      {ST_FETCH3, OPC_BRANCH, 1'b?, 1'b?}: begin ctrl = cAluToReg(AL_INC4, RS_PC); nextState = ST_BR0;   end
      {ST_FETCH3, {OP_W{1'b?}}, 1'b?, 1'b?}: begin ctrl = cAluToReg(AL_INC4, RS_PC); nextState = ST_FETCH0; end
      // register-register ALU
      {ST_ALU0, {OP_W{1'b?}}, 1'b?, 1'b?}: begin ctrl = cRegToA(RS_RS1); nextState = ST_ALU1; end
      {ST_ALU1, {OP_W{1'b?}}, 1'b?, 1'b?}: begin ctrl = cRegToB(RS_RS2); nextState = ST_ALU2; end
      {ST_ALU2, {OP_W{1'b?}}, 1'b?, 1'b?}: begin ctrl = cAluToReg(AL_FUNC, RS_RD); nextState = ST_FETCH0; end
      // register-immediate ALU
      {ST_ALUI0, {OP_W{1'b?}}, 1'b?, 1'b?}: begin ctrl = cRegToA(RS_RS1); nextState = ST_ALUI1; end
      {ST_ALUI1, {OP_W{1'b?}}, 1'b?, 1'b?}: begin ctrl = cImmToB(IM_I);  nextState = ST_ALUI2; end
      {ST_ALUI2, {OP_W{1'b?}}, 1'b?, 1'b?}: begin ctrl = cAluToReg(AL_FUNC, RS_RD); nextState = ST_FETCH0; end
      // load
      {ST_LD0, {OP_W{1'b?}}, 1'b?, 1'b?}: begin ctrl = cRegToA(RS_RS1);  nextState = ST_LD1; end
      {ST_LD1, {OP_W{1'b?}}, 1'b?, 1'b?}: begin ctrl = cImmToB(IM_I);   nextState = ST_LD2; end
      {ST_LD2, {OP_W{1'b?}}, 1'b?, 1'b?}: begin ctrl = cAluToMa(AL_ADD); nextState = ST_LD3; end
      {ST_LD3, {OP_W{1'b?}}, 1'b?, 1'b1}: begin ctrl = cStall(cMemToReg(RS_RD)); nextState = ST_LD3; end
      {ST_LD3, {OP_W{1'b?}}, 1'b?, 1'b0}: begin ctrl = cMemToReg(RS_RD); nextState = ST_FETCH0; end
      // store
      {ST_ST0, {OP_W{1'b?}}, 1'b?, 1'b?}: begin ctrl = cRegToA(RS_RS1);  nextState = ST_ST1; end
      {ST_ST1, {OP_W{1'b?}}, 1'b?, 1'b?}: begin ctrl = cImmToB(IM_S);   nextState = ST_ST2; end
      {ST_ST2, {OP_W{1'b?}}, 1'b?, 1'b?}: begin ctrl = cAluToMa(AL_ADD); nextState = ST_ST3; end
      {ST_ST3, {OP_W{1'b?}}, 1'b?, 1'b1}: begin ctrl = cStall(cRegToMem(RS_RS2)); nextState = ST_ST3; end
      {ST_ST3, {OP_W{1'b?}}, 1'b?, 1'b0}: begin ctrl = cRegToMem(RS_RS2); nextState = ST_FETCH0; end
      // jump
      {ST_JMP0, {OP_W{1'b?}}, 1'b?, 1'b?}: begin ctrl = cRegToA(RS_PC);    nextState = ST_JMP1; end
      {ST_JMP1, {OP_W{1'b?}}, 1'b?, 1'b?}: begin ctrl = cAluToA(AL_DEC4);  nextState = ST_JMP2; end
      {ST_JMP2, {OP_W{1'b?}}, 1'b?, 1'b?}: begin ctrl = cImmToB(IM_J);     nextState = ST_JMP3; end
      {ST_JMP3, {OP_W{1'b?}}, 1'b?, 1'b?}: begin ctrl = cAluToReg(AL_ADD, RS_PC); nextState = ST_FETCH0; end
      // branch if equal
      {ST_BR0, {OP_W{1'b?}}, 1'b?, 1'b?}: begin ctrl = cRegToA(RS_RS1); nextState = ST_BR1; end
      {ST_BR1, {OP_W{1'b?}}, 1'b?, 1'b?}: begin ctrl = cRegToB(RS_RS2); nextState = ST_BR2; end
      {ST_BR2, {OP_W{1'b?}}, 1'b1, 1'b?}: begin ctrl = '0; nextState = ST_BT0;    end
      {ST_BR2, {OP_W{1'b?}}, 1'b0, 1'b?}: begin ctrl = '0; nextState = ST_FETCH0; end
      {ST_BT0, {OP_W{1'b?}}, 1'b?, 1'b?}: begin ctrl = cRegToA(RS_PC);   nextState = ST_BT1; end
      {ST_BT1, {OP_W{1'b?}}, 1'b?, 1'b?}: begin ctrl = cAluToA(AL_DEC4); nextState = ST_BT2; end
      {ST_BT2, {OP_W{1'b?}}, 1'b?, 1'b?}: begin ctrl = cImmToB(IM_B);    nextState = ST_BT3; end
      {ST_BT3, {OP_W{1'b?}}, 1'b?, 1'b?}: begin ctrl = cAluToReg(AL_ADD, RS_PC); nextState = ST_FETCH0; end
      default: begin ctrl = '0; nextState = ST_FETCH0; end
    endcase
  end

endmodule

// File: rtl/useqSequencer.sv
module useqSequencer
  import useqPkg::*;
#(
  parameter bit SYNC_RST = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [OP_W-1:0]   opcode,
  input  logic              cmpEq,
  input  logic              memBusy,
  output logic              ldIr,
  output logic              ldA,
  output logic              ldB,
  output logic              ldMa,
  output logic              regWr,
  output logic              memWr,
  output logic              drvReg,
  output logic              drvImm,
  output logic              drvAlu,
  output logic              drvMem,
  output logic [1:0]        regSel,
  output logic [1:0]        immSel,
  output logic [2:0]        aluSel
);

  uState_e curState;
  uState_e nextState;
  ctrl_t   ctrl;

  useqStateReg #(.SYNC_RST(SYNC_RST)) u_stateReg (
    .clk       (clk),
    .rst       (rst),
    .nextState (nextState),
    .curState  (curState)
  );

  useqTable u_table (
    .curState  (curState),
    .opcode    (opcode),
    .cmpEq     (cmpEq),
    .memBusy   (memBusy),
    .ctrl      (ctrl),
    .nextState (nextState)
  );

  assign ldIr   = ctrl.ldIr;
  assign ldA    = ctrl.ldA;
  assign ldB    = ctrl.ldB;
  assign ldMa   = ctrl.ldMa;
  assign regWr  = ctrl.regWr;
  assign memWr  = ctrl.memWr;
  assign drvReg = ctrl.drvReg;
  assign drvImm = ctrl.drvImm;
  assign drvAlu = ctrl.drvAlu;
  assign drvMem = ctrl.drvMem;
  assign regSel = ctrl.regSel;
  assign immSel = ctrl.immSel;
  assign aluSel = ctrl.aluSel;

  logic memStall;
  assign memStall = memBusy && (drvMem || memWr);

  // R12: one bus source at most
  a_r12_single_driver: assert property (@(posedge clk) disable iff (rst)
    $onehot0({drvReg, drvImm, drvAlu, drvMem}));

  // R3: a busy memory state keeps its micro-state
  a_r3_stall_holds: assert property (@(posedge clk) disable iff (rst)
    memStall |=> (curState == $past(curState)));

  // R3: nothing is loaded while waiting on memory
  a_r3_no_load_in_stall: assert property (@(posedge clk) disable iff (rst)
    memStall |-> !(ldIr || ldA || ldB || ldMa || regWr));

  // R2: the first fetch state always moves on
  a_r2_fetch_advance: assert property (@(posedge clk) disable iff (rst)
    (curState == ST_FETCH0) |=> (curState == ST_FETCH1));

  // R10: a not-taken branch goes back to fetch
  a_r10_not_taken: assert property (@(posedge clk) disable iff (rst)
    (curState == ST_BR2 && !cmpEq) |=> (curState == ST_FETCH0));

  // R11: an unlisted opcode goes back to fetch
  a_r11_unknown_op: assert property (@(posedge clk) disable iff (rst)
    (curState == ST_FETCH3 && !isKnownOp(opcode)) |=> (curState == ST_FETCH0));

endmodule

// File: tb/useqSequencer_bench.sv
module useqSequencer_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [6:0] opcode = '0;
  logic       cmpEq = 1'b0;
  logic       memBusy = 1'b0;
  logic ldIr, ldA, ldB, ldMa, regWr, memWr, drvReg, drvImm, drvAlu, drvMem;
  logic [1:0] regSel, immSel;
  logic [2:0] aluSel;

  always #5 clk = ~clk;

  useqSequencer u_useqSequencer (
    .clk(clk), .rst(rst), .opcode(opcode), .cmpEq(cmpEq), .memBusy(memBusy),
    .ldIr(ldIr), .ldA(ldA), .ldB(ldB), .ldMa(ldMa), .regWr(regWr), .memWr(memWr),
    .drvReg(drvReg), .drvImm(drvImm), .drvAlu(drvAlu), .drvMem(drvMem),
    .regSel(regSel), .immSel(immSel), .aluSel(aluSel)
  );

  // Encodings taken from the requirements
  localparam int PC = 0, RS1 = 1, RS2 = 2, RD = 3;
  localparam int II = 0, IS = 1, IB = 2, IJ = 3;
  localparam int ANONE = 0, AADD = 1, AINC = 2, ADEC = 3, AFUN = 4;
  localparam logic [6:0] OP_ALU = 7'b0110011, OP_ALUI = 7'b0010011, OP_LD = 7'b0000011,
                         OP_ST = 7'b0100011, OP_JMP = 7'b1101111, OP_BR = 7'b1100011,
                         OP_BAD = 7'b1111111;

  typedef struct {
    logic [16:0] exp;
    string       tag;
  } item_t;

  item_t scoreQ[$];
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  function automatic logic [16:0] ew(bit li, bit la, bit lb, bit lm, bit rw, bit mw,
                                     bit dr, bit di, bit da, bit dm, int rs, int im, int al);
    return {li, la, lb, lm, rw, mw, dr, di, da, dm, 2'(rs), 2'(im), 3'(al)};
  endfunction

  function automatic logic [16:0] wRegA(int rs);   return ew(0,1,0,0,0,0,1,0,0,0,rs,0,0); endfunction
  function automatic logic [16:0] wRegB(int rs);   return ew(0,0,1,0,0,0,1,0,0,0,rs,0,0); endfunction
  function automatic logic [16:0] wRegMa(int rs);  return ew(0,0,0,1,0,0,1,0,0,0,rs,0,0); endfunction
  function automatic logic [16:0] wImmB(int im);   return ew(0,0,1,0,0,0,0,1,0,0,0,im,0); endfunction
  function automatic logic [16:0] wAluA(int al);   return ew(0,1,0,0,0,0,0,0,1,0,0,0,al); endfunction
  function automatic logic [16:0] wAluMa(int al);  return ew(0,0,0,1,0,0,0,0,1,0,0,0,al); endfunction
  function automatic logic [16:0] wAluReg(int al, int rs); return ew(0,0,0,0,1,0,0,0,1,0,rs,0,al); endfunction

  logic [16:0] obs;
  assign obs = {ldIr, ldA, ldB, ldMa, regWr, memWr, drvReg, drvImm, drvAlu, drvMem,
                regSel, immSel, aluSel};

  // Monitor: pops one expected word per cycle, sampled mid-low-phase
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (scoreQ.size() > 0) begin
        item_t it;
        it = scoreQ.pop_front();
        checks++;
        if (obs !== it.exp) begin
          fails++;
          $display("FAIL %s: actual=%b expected=%b", it.tag, obs, it.exp);
        end
      end
    end
  end

  // Driver: one micro-step per cycle
  task automatic step(logic [6:0] op, bit cmp, bit busy, logic [16:0] exp, string tag);
    item_t it;
    opcode = op; cmpEq = cmp; memBusy = busy;
    it.exp = exp; it.tag = tag;
    scoreQ.push_back(it);
    @(negedge clk);
  endtask

  task automatic fetchRest(logic [6:0] op, int nBusy, bit busyElse);
    for (int i = 0; i < nBusy; i++)
      step(op, 0, 1, ew(0,0,0,0,0,0,0,0,0,1,0,0,0), "R3 fetch read stall");
    step(op, 0, 0, ew(1,0,0,0,0,0,0,0,0,1,0,0,0), "R2 fetch1 IR<-mem");
    step(op, 0, busyElse, wRegA(PC), "R2 fetch2 A<-PC (R3 busy ignored)");
    step(op, 0, busyElse, wAluReg(AINC, PC), "R2 fetch3 PC<-A+4 / R4 dispatch");
  endtask

  task automatic fetch(logic [6:0] op, int nBusy, bit busyElse, string f0tag);
    step(op, 0, busyElse, wRegMa(PC), f0tag);
    fetchRest(op, nBusy, busyElse);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state, then ALU routine with stray cmpEq (R10 ignored)
    step(OP_ALU, 0, 0, wRegMa(PC), "R1 reset in fetch0");
    fetchRest(OP_ALU, 2, 1'b0);
    step(OP_ALU, 1, 0, wRegA(RS1), "R5 A<-rs1");
    step(OP_ALU, 1, 0, wRegB(RS2), "R5 B<-rs2 (R10 cmp ignored)");
    step(OP_ALU, 1, 0, wAluReg(AFUN, RD), "R5 rd<-func");
    // ALU immediate with busy raised in non-memory states
    fetch(OP_ALUI, 0, 1'b1, "R5 return to fetch0");
    step(OP_ALUI, 0, 1, wRegA(RS1), "R6 A<-rs1 (R3 busy ignored)");
    step(OP_ALUI, 0, 1, wImmB(II), "R6 B<-immI");
    step(OP_ALUI, 0, 1, wAluReg(AFUN, RD), "R6 rd<-func");
    // load with a data stall
    fetch(OP_LD, 1, 1'b0, "R6 return to fetch0");
    step(OP_LD, 0, 0, wRegA(RS1), "R7 A<-rs1");
    step(OP_LD, 0, 0, wImmB(II), "R7 B<-immI");
    step(OP_LD, 0, 0, wAluMa(AADD), "R7 MA<-A+B");
    step(OP_LD, 0, 1, ew(0,0,0,0,0,0,0,0,0,1,RD,0,0), "R3 load stall");
    step(OP_LD, 0, 1, ew(0,0,0,0,0,0,0,0,0,1,RD,0,0), "R3 load stall");
    step(OP_LD, 0, 0, ew(0,0,0,0,1,0,0,0,0,1,RD,0,0), "R7 rd<-mem");
    // store with a write stall
    fetch(OP_ST, 0, 1'b0, "R7 return to fetch0");
    step(OP_ST, 0, 0, wRegA(RS1), "R8 A<-rs1");
    step(OP_ST, 0, 0, wImmB(IS), "R8 B<-immS");
    step(OP_ST, 0, 0, wAluMa(AADD), "R8 MA<-A+B");
    step(OP_ST, 0, 1, ew(0,0,0,0,0,1,1,0,0,0,RS2,0,0), "R3 store stall");
    step(OP_ST, 0, 0, ew(0,0,0,0,0,1,1,0,0,0,RS2,0,0), "R8 mem<-rs2");
    // jump
    fetch(OP_JMP, 0, 1'b0, "R8 return to fetch0");
    step(OP_JMP, 0, 0, wRegA(PC), "R9 A<-PC");
    step(OP_JMP, 0, 0, wAluA(ADEC), "R9 A<-A-4");
    step(OP_JMP, 0, 0, wImmB(IJ), "R9 B<-immJ");
    step(OP_JMP, 0, 0, wAluReg(AADD, PC), "R9 PC<-A+B");
    // branch not taken
    fetch(OP_BR, 0, 1'b0, "R9 return to fetch0");
    step(OP_BR, 0, 0, wRegA(RS1), "R10 A<-rs1");
    step(OP_BR, 0, 0, wRegB(RS2), "R10 B<-rs2");
    step(OP_BR, 0, 0, ew(0,0,0,0,0,0,0,0,0,0,0,0,0), "R10 decision idle");
    // branch taken
    fetch(OP_BR, 0, 1'b0, "R10 not-taken returns to fetch0");
    step(OP_BR, 0, 0, wRegA(RS1), "R10 A<-rs1");
    step(OP_BR, 0, 0, wRegB(RS2), "R10 B<-rs2");
    step(OP_BR, 1, 0, ew(0,0,0,0,0,0,0,0,0,0,0,0,ANONE), "R12 decision all zero");
    step(OP_BR, 0, 0, wRegA(PC), "R10 taken A<-PC");
    step(OP_BR, 0, 0, wAluA(ADEC), "R10 taken A<-A-4");
    step(OP_BR, 0, 0, wImmB(IB), "R10 taken B<-immB");
    step(OP_BR, 0, 0, wAluReg(AADD, PC), "R10 taken PC<-A+B");
    // unknown opcode
    fetch(OP_BAD, 0, 1'b0, "R10 taken returns to fetch0");
    fetch(OP_ALU, 0, 1'b0, "R11 unknown op returns to fetch0");
    step(OP_ALU, 0, 0, wRegA(RS1), "R4 ALU dispatch after unknown");
    wait (scoreQ.size() == 0);
    @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R2 watchdog: actual=hung expected=complete");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule